// File: doc/BRIEF.md
# Alarm Compare and Interrupt Flags

This block holds three alarm bytes, one each for seconds, minutes and hours, and compares them with the current time bytes each time the time advances. It also keeps a small event-flag register. Three events can set a flag: an alarm match, a periodic tick and the end of a time update. From the flags and three interrupt enables it builds a summary bit and an active-low interrupt line.

The alarm bytes are loaded through a register-index write port. The flag register is read as a byte, and a read strobe clears it as a side effect. An alarm byte whose top two bits are both set acts as a "don't care" and matches every value of its field. The block does not count time and does not decode the bus. It only consumes the time bytes, the event pulses, the enables and the strobes.

Top module: `alarm_irq_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), flags_out is 0x00, irq_n is 1 and all three alarm bytes hold 0x00.
- R2: A write (reg_wr high) to index 1 loads the seconds alarm, index 3 the minutes alarm and index 5 the hours alarm. A write to any other index changes no alarm byte.
- R3: An alarm byte whose bits 7 and 6 are both 1 (0xC0 to 0xFF) matches every value of its time field. Any other alarm byte matches only an equal time byte.
- R4: The alarm flag (flags_out bit 5) is set at the clock edge where time_tick is high and all three fields match. Without time_tick, no match sets it.
- R5: A periodic_tick pulse sets flags_out bit 6 and an update_done pulse sets flags_out bit 4. Both flags, and the alarm flag, are set whatever the enables are.
- R6: flags_out bit 7 is 1 exactly when some event flag is set and its enable is set. irq_en[2], irq_en[1] and irq_en[0] enable bits 6, 5 and 4. flags_out bits 3:0 always read 0.
- R7: irq_n is 0 exactly when flags_out bit 7 is 1.
- R8: Event flags stay set until flag_rd is high at a clock edge. That edge clears every flag bit.
- R9: An event that arrives at the same edge as flag_rd stays set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| time_tick | input | 1 | One-cycle pulse when the time advances |
| periodic_tick | input | 1 | One-cycle periodic event pulse |
| update_done | input | 1 | One-cycle update-ended pulse |
| reg_wr | input | 1 | Alarm byte write strobe |
| reg_idx | input | 4 | Register index for the write |
| reg_wdata | input | 8 | Write data |
| irq_en | input | 3 | Enables {periodic, alarm, update} |
| flag_rd | input | 1 | Flag register read strobe (clears on the edge) |
| flags_out | output | 8 | Flag byte: bit 7 summary, bits 6..4 events |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the event inputs are single-cycle strobes sampled at the clock edge. They also assume that flag_rd marks exactly the edge at which a read takes effect, so a flag may only rise after its own pulse, and a flag with no read stays set. The stimulus drives every input just after the falling edge and holds it for one full cycle. It fires time_tick, periodic_tick and update_done at random with moderate probability, and it often sets the time bytes equal to the loaded alarm values so that matches occur. Directed cases cover wildcard bytes, writes to unused indices, and events that coincide with a read.

// File: rtl/alarm_irq_pkg.sv
// Package: shared widths, flag bit positions and the alarm field compare.
// Assumes 8-bit time bytes; the wildcard code uses the top two bits.
package alarm_irq_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 4;
    localparam int NUM_FIELDS = 3;
    localparam int EVT_W      = 3;
    localparam int BIT_SUM    = 7;
    localparam int BIT_PER    = 6;
    localparam int BIT_ALM    = 5;
    localparam int BIT_UPD    = 4;

    typedef logic [DATA_W-1:0] tbyte_t;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;

    // True when the alarm byte is a wildcard or equals the time byte.
    function automatic logic field_hit(tbyte_t alarm_b, tbyte_t now_b);
        return (alarm_b[DATA_W-1:DATA_W-2] == 2'b11) || (alarm_b == now_b);
    endfunction
endpackage

// File: rtl/alarm_slot.sv
// alarm_slot: holds one alarm byte loaded by index and reports a field match.
// Assumes the writer presents index and data with the write strobe in one cycle.
module alarm_slot
    import alarm_irq_pkg::*;
#(
    parameter int SLOT_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tbyte_t           wr_data,
    input  tbyte_t           now_val,
    output logic             hit
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT_IDX);

    tbyte_t alarm_q;

    // Load the alarm byte when the write targets this slot's index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= '0;
        else if (wr_en && (wr_idx == MY_IDX))
            alarm_q <= wr_data;
    end

    // Compare the stored byte with the live time byte.
    always_comb begin
        hit = field_hit(alarm_q, now_val);
    end
endmodule

// File: rtl/event_flags.sv
// event_flags: sticky event flags, cleared by a read strobe.
// Assumes a new event on the read edge must survive the clear.
module event_flags
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_in,
    input  logic rd_clr,
    output evt_t flags_q
);
    evt_t kept;

    // Keep old flags unless a read is clearing them.
    always_comb begin
        kept = rd_clr ? '0 : flags_q;
    end

    // Merge new events into the kept flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= kept | evt_in;
    end
endmodule

// File: rtl/status_merge.sv
// status_merge: builds the flag byte and the active-low interrupt.
// Assumes the enable order {periodic, alarm, update} matches the event struct.
module status_merge
    import alarm_irq_pkg::*;
(
    input  evt_t             flags,
    input  logic [EVT_W-1:0] enables,
    output tbyte_t           flag_byte,
    output logic             irq_n
);
    logic summary;

    // Summary is any flag whose enable is set.
    always_comb begin
        summary = |(flags & enables);
    end

    // Assemble the byte: summary on top, events below, low bits zero.
    always_comb begin
        flag_byte          = '0;
        flag_byte[BIT_SUM] = summary;
        flag_byte[BIT_PER] = flags.per;
        flag_byte[BIT_ALM] = flags.alm;
        flag_byte[BIT_UPD] = flags.upd;
        irq_n              = ~summary;
    end
endmodule

// File: rtl/alarm_irq_unit.sv
// alarm_irq_unit: three alarm compares, sticky event flags and interrupt line.
// Assumes the event pulses and time_tick last one cycle each.
module alarm_irq_unit
    import alarm_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cur_sec,
    input  logic [7:0]       cur_min,
    input  logic [7:0]       cur_hour,
    input  logic             time_tick,
    input  logic             periodic_tick,
    input  logic             update_done,
    input  logic             reg_wr,
    input  logic [3:0]       reg_idx,
    input  logic [7:0]       reg_wdata,
    input  logic [2:0]       irq_en,
    input  logic             flag_rd,
    output logic [7:0]       flags_out,
    output logic             irq_n
);
    tbyte_t                now_vec [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hits;
    evt_t                  evt_now;
    evt_t                  flags_q;

    // Order the time bytes as seconds, minutes, hours.
    always_comb begin
        now_vec[0] = cur_sec;
        now_vec[1] = cur_min;
        now_vec[2] = cur_hour;
    end

    // One slot per field, at odd register indices 1, 3, 5.
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_slot
        alarm_slot #(.SLOT_IDX(2 * gi + 1)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr),
            .wr_idx  (reg_idx),
            .wr_data (reg_wdata),
            .now_val (now_vec[gi]),
            .hit     (hits[gi])
        );
    end

    // Collect this cycle's events; the alarm is only tested on a time tick.
    always_comb begin
        evt_now.per = periodic_tick;
        evt_now.alm = time_tick && (&hits);
        evt_now.upd = update_done;
    end

    event_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_now),
        .rd_clr  (flag_rd),
        .flags_q (flags_q)
    );

    status_merge u_merge (
        .flags     (flags_q),
        .enables   (irq_en),
        .flag_byte (flags_out),
        .irq_n     (irq_n)
    );
endmodule

// File: rtl/alarm_irq_unit_chk.sv
// alarm_irq_unit_chk: temporal checks on the flag byte and interrupt line.
module alarm_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       time_tick,
    input logic       periodic_tick,
    input logic       update_done,
    input logic [2:0] irq_en,
    input logic       flag_rd,
    input logic [7:0] flags_out,
    input logic       irq_n
);
    a_r4_alarm_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_out[5]) |-> $past(time_tick));

    a_r5_periodic_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_out[6]) |-> $past(periodic_tick));

    a_r5_update_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_out[4]) |-> $past(update_done));

    a_r7_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|(flags_out[6:4] & irq_en)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out[6] && !flag_rd) |=> flags_out[6]);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !time_tick && !periodic_tick && !update_done) |=> (flags_out == 8'h00));

    a_r9_event_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && update_done) |=> flags_out[4]);

    a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[3:0] == 4'h0);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .time_tick     (time_tick),
    .periodic_tick (periodic_tick),
    .update_done   (update_done),
    .irq_en        (irq_en),
    .flag_rd       (flag_rd),
    .flags_out     (flags_out),
    .irq_n         (irq_n)
);

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cur_sec, cur_min, cur_hour;
    logic       time_tick, periodic_tick, update_done;
    logic       reg_wr;
    logic [3:0] reg_idx;
    logic [7:0] reg_wdata;
    logic [2:0] irq_en;
    logic       flag_rd;
    logic [7:0] flags_out;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_alarm [3];
    logic [2:0] m_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alarm_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .time_tick(time_tick), .periodic_tick(periodic_tick),
        .update_done(update_done), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .irq_en(irq_en), .flag_rd(flag_rd),
        .flags_out(flags_out), .irq_n(irq_n)
    );

    function automatic logic ref_hit(logic [7:0] a, logic [7:0] t);
        return (a >= 8'hC0) || (a == t);
    endfunction

    function automatic logic [7:0] ref_byte(logic [2:0] f, logic [2:0] en);
        logic s;
        s = |(f & en);
        return {s, f, 4'h0};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        time_tick = 0; periodic_tick = 0; update_done = 0;
        reg_wr = 0; flag_rd = 0;
    endtask

    // One clock: update model from current inputs, then compare after the edge.
    task automatic step(input string tag);
        logic [2:0] ev;
        ev[1] = time_tick && ref_hit(m_alarm[0], cur_sec) &&
                ref_hit(m_alarm[1], cur_min) && ref_hit(m_alarm[2], cur_hour);
        ev[2] = periodic_tick;
        ev[0] = update_done;
        m_flags = (flag_rd ? 3'b000 : m_flags) | ev;
        if (reg_wr) begin
            if (reg_idx == 4'd1) m_alarm[0] = reg_wdata;
            if (reg_idx == 4'd3) m_alarm[1] = reg_wdata;
            if (reg_idx == 4'd5) m_alarm[2] = reg_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        check(flags_out == ref_byte(m_flags, irq_en), tag, flags_out, ref_byte(m_flags, irq_en));
        check(irq_n == ~flags_out[7], {tag, " R7"}, irq_n, ~flags_out[7]);
        idle_inputs();
    endtask

    task automatic write_alarm(input logic [3:0] idx, input logic [7:0] v);
        reg_wr = 1; reg_idx = idx; reg_wdata = v;
        step("R2 write");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        cur_sec = 0; cur_min = 0; cur_hour = 0; reg_idx = 0; reg_wdata = 0;
        irq_en = 3'b111; rst_n = 0;
        m_alarm[0] = 0; m_alarm[1] = 0; m_alarm[2] = 0; m_flags = 0;
        @(negedge clk); @(negedge clk);
        check(flags_out == 8'h00, "R1 flags reset", flags_out, 0);
        check(irq_n == 1'b1, "R1 irq reset", irq_n, 1);
        rst_n = 1;
        // R1: reset alarms are 0x00, so time 00:00:00 with a tick matches.
        time_tick = 1;
        step("R1 R4 reset alarm match");
        check(flags_out[5] == 1'b1, "R1 alarm zero", flags_out[5], 1);
        flag_rd = 1; step("R8 clear");
        check(flags_out == 8'h00, "R8 read clears", flags_out, 0);

        // R2: load 12:34:56, then write unused indices 0, 2, 4.
        write_alarm(4'd1, 8'h56); write_alarm(4'd3, 8'h34); write_alarm(4'd5, 8'h12);
        write_alarm(4'd0, 8'hC0); write_alarm(4'd2, 8'hC0); write_alarm(4'd4, 8'hC0);
        cur_sec = 8'h57; cur_min = 8'h34; cur_hour = 8'h12; time_tick = 1;
        step("R2 unused index ignored");
        check(flags_out[5] == 1'b0, "R2 no match", flags_out[5], 0);
        // R4: match without tick does nothing; with tick sets.
        cur_sec = 8'h56;
        step("R4 no tick");
        check(flags_out[5] == 1'b0, "R4 no tick no flag", flags_out[5], 0);
        time_tick = 1; step("R4 tick match");
        check(flags_out[5] == 1'b1, "R4 tick sets", flags_out[5], 1);
        // R3: wildcard seconds 0xC3 matches any second.
        flag_rd = 1; step("R8 clear");
        write_alarm(4'd1, 8'hC3);
        cur_sec = 8'h09; time_tick = 1; step("R3 wildcard");
        check(flags_out[5] == 1'b1, "R3 wildcard hit", flags_out[5], 1);
        // R3: 0x80 (only bit 7) is not a wildcard.
        flag_rd = 1; step("R8 clear");
        write_alarm(4'd1, 8'h80);
        time_tick = 1; step("R3 non-wildcard");
        check(flags_out[5] == 1'b0, "R3 0x80 no hit", flags_out[5], 0);
        // R5/R6: flags set with enables off; bit 7 stays low.
        irq_en = 3'b000;
        periodic_tick = 1; update_done = 1; step("R5 disabled set");
        check(flags_out == 8'h50, "R5 R6 flags no summary", flags_out, 8'h50);
        check(irq_n == 1'b1, "R7 idle", irq_n, 1);
        irq_en = 3'b001; step("R6 enable update");
        check(flags_out[7] == 1'b1, "R6 summary", flags_out[7], 1);
        // R9: event on the read edge survives.
        flag_rd = 1; periodic_tick = 1; step("R9 event on read");
        check(flags_out[6:4] == 3'b100, "R9 survive", flags_out[6:4], 3'b100);
        flag_rd = 1; step("R8 clear");

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                reg_wr = 1;
                reg_idx = 4'($urandom_range(0, 6));
                reg_wdata = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hFF))
                                                        : 8'($urandom_range(0, 3));
            end
            cur_sec  = 8'($urandom_range(0, 3));
            cur_min  = 8'($urandom_range(0, 3));
            cur_hour = 8'($urandom_range(0, 3));
            time_tick     = ($urandom_range(0, 2) == 0);
            periodic_tick = ($urandom_range(0, 5) == 0);
            update_done   = ($urandom_range(0, 5) == 0);
            flag_rd       = ($urandom_range(0, 4) == 0);
            irq_en        = 3'($urandom_range(0, 7));
            step("R4 R5 R6 R8 R9 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule